// File: doc/BRIEF.md
# Receive Byte Queue with Interrupt Status Flags

The block is a byte queue that sits between a packet receiver and a host. The receiver pushes bytes in through a write strobe and the host pops them through a read strobe. The block keeps an occupancy count and a small set of event flags, and it presents all of them as one status byte that an interrupt controller can watch. The queue holds 66 entries. This depth is not a power of two, so the pointers wrap by comparison rather than by overflow.

The host loads a level threshold, and a level bit reports when the stored count rises strictly above it. The receiver signals the end of a payload together with its check result. From these the block raises a payload-ready flag and a check-passed flag, and it drops both again when the queue drains. The block also keeps a sticky overflow flag, which is never raised in sleep mode, and a sticky supply-warning flag. Both are cleared by writing 1 to the matching status bit. Clearing the overflow bit also empties the queue, so the next reception can start at once.

Top module: `rxq_status_fifo`

## Requirements
- R1: The queue stores up to 66 bytes. Status bit 7 (full) is 1 exactly when 66 bytes are stored. A write while full is discarded and leaves the stored bytes unchanged.
- R2: Status bit 6 (not-empty) is 1 whenever at least one byte is stored.
- R3: Status bit 5 (level) is 1 only when the stored count is strictly greater than `level_thr_i`, and 0 otherwise.
- R4: Status bit 4 (overflow) is set by a write attempted while full, unless `sleep_i` is high. Once set, it stays set until it is cleared.
- R5: When `clr_wr_i` is high and `clr_data_i[4]` is 1, the queue empties and bits 7..1 all read 0 on the next cycle. A write in that same cycle is dropped, and a write in the following cycle is accepted.
- R6: Status bit 2 (payload-ready) is set when `rx_mode_i` and `payload_end_i` are both high, provided that `crc_en_i` is low, or `autoclr_off_i` is high, or `crc_good_i` is high.
- R7: Status bit 1 (check-passed) is set when `rx_mode_i`, `payload_end_i` and `crc_good_i` are all high.
- R8: Bits 2 and 1 clear in the cycle after the queue becomes empty. They are never 1 while the queue is empty.
- R9: Status bit 0 (supply warning) is set by `lowbat_evt_i` and clears only when `clr_wr_i` is high with `clr_data_i[0]` = 1. If both happen in the same cycle, the set wins.
- R10: After reset all status bits are 0. Bit 3 always reads 0.
- R11: Bytes are read in the order they were written. `rd_data_o` shows the oldest byte, or 0 when the queue is empty. A read while empty changes nothing. A read and a write together, when the queue is neither empty nor full, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep mode; suppresses overflow flagging |
| rx_mode_i | input | 1 | Receive mode; qualifies payload events |
| wr_en_i | input | 1 | Push a byte from the receiver |
| wr_data_i | input | 8 | Byte to push |
| rd_en_i | input | 1 | Pop the oldest byte |
| rd_data_o | output | 8 | Oldest byte, 0 when empty |
| level_thr_i | input | 7 | Level threshold |
| payload_end_i | input | 1 | Last byte of payload received |
| crc_good_i | input | 1 | Payload check passed |
| crc_en_i | input | 1 | Payload checking enabled |
| autoclr_off_i | input | 1 | Do not require a good check for payload-ready |
| lowbat_evt_i | input | 1 | Supply warning event |
| clr_wr_i | input | 1 | Host write strobe to the status byte |
| clr_data_i | input | 8 | Write-1-to-clear mask (bits 4 and 0 act) |
| status_o | output | 8 | Status byte |

## Verification
Every flag register and the count update on the clock edge where their stimulus is sampled. Full, not-empty, overflow, payload-ready, check-passed and supply-warning are therefore due one cycle after the stimulus. The level bit and `rd_data_o` also follow `level_thr_i` and the head entry combinationally. The bench drives inputs at the falling edge and updates its reference model just after the rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed sequences cover filling to 66 bytes, overflow, flush with a write in the same cycle and one in the next, and draining until the payload flags drop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Status byte bit positions (host software decodes these)
   localparam int ST_FULL  = 7;
   localparam int ST_NEMP  = 6;
   localparam int ST_LEVEL = 5;
   localparam int ST_OVR   = 4;
   localparam int ST_RSVD  = 3;
   localparam int ST_PRDY  = 2;
   localparam int ST_CRCOK = 1;
   localparam int ST_LBAT  = 0;

   typedef struct packed {
      logic ovr;
      logic prdy;
      logic crcok;
      logic lbat;
   } rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 66,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_nxt
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_inc, rp_inc;

   // Pointer advance: natural wrap for power-of-two depth, compare otherwise
   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wp_inc = wp + AW'(1);
         assign rp_inc = rp + AW'(1);
      end else begin : g_odd
         assign wp_inc = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_inc = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_comb begin
      if (flush)
         count_nxt = '0;
      else
         count_nxt = count + CW'(push) - CW'(pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         count <= count_nxt;
         if (flush) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (push) wp <= wp_inc;
            if (pop)  rp <= rp_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   assign head = mem[rp];
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
   parameter int CW = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ovr_set,
   input  logic                flush,
   input  logic                prdy_set,
   input  logic                crcok_set,
   input  logic                lbat_set,
   input  logic                lbat_clr,
   input  logic [CW-1:0]       count_nxt,
   output rxq_pkg::rxq_flags_t flags
);
   logic drains;
   assign drains = (count_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (flush)        flags.ovr <= 1'b0;
         else if (ovr_set) flags.ovr <= 1'b1;

         flags.prdy  <= (flags.prdy  | prdy_set)  & ~drains;
         flags.crcok <= (flags.crcok | crcok_set) & ~drains;

         if (lbat_set)      flags.lbat <= 1'b1;
         else if (lbat_clr) flags.lbat <= 1'b0;
      end
   end
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 66,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic          rx_mode_i,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_en_i,
   output logic [DW-1:0] rd_data_o,
   input  logic [CW-1:0] level_thr_i,
   input  logic          payload_end_i,
   input  logic          crc_good_i,
   input  logic          crc_en_i,
   input  logic          autoclr_off_i,
   input  logic          lowbat_evt_i,
   input  logic          clr_wr_i,
   input  logic [7:0]    clr_data_i,
   output logic [7:0]    status_o
);
   import rxq_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_status_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("rxq_status_fifo: DW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] count, count_nxt;
   logic [DW-1:0] head;
   logic          full, empty, flush, push, pop;
   rxq_flags_t    flags;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign flush = clr_wr_i & clr_data_i[ST_OVR];
   assign push  = wr_en_i & ~full & ~flush;
   assign pop   = rd_en_i & ~empty & ~flush;

   rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .flush     (flush),
      .wdata     (wr_data_i),
      .head      (head),
      .count     (count),
      .count_nxt (count_nxt)
   );

   logic payload_evt;
   assign payload_evt = rx_mode_i & payload_end_i;

   rxq_flags #(.CW(CW)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovr_set   (wr_en_i & full & ~sleep_i),
      .flush     (flush),
      .prdy_set  (payload_evt & (~crc_en_i | autoclr_off_i | crc_good_i)),
      .crcok_set (payload_evt & crc_good_i),
      .lbat_set  (lowbat_evt_i),
      .lbat_clr  (clr_wr_i & clr_data_i[ST_LBAT]),
      .count_nxt (count_nxt),
      .flags     (flags)
   );

   assign rd_data_o = empty ? '0 : head;

   always_comb begin
      status_o           = '0;
      status_o[ST_FULL]  = full;
      status_o[ST_NEMP]  = ~empty;
      status_o[ST_LEVEL] = (count > level_thr_i);
      status_o[ST_OVR]   = flags.ovr;
      status_o[ST_RSVD]  = 1'b0;
      status_o[ST_PRDY]  = flags.prdy;
      status_o[ST_CRCOK] = flags.crcok;
      status_o[ST_LBAT]  = flags.lbat;
   end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_i,
   input logic       wr_en_i,
   input logic       rd_en_i,
   input logic       clr_wr_i,
   input logic [7:0] clr_data_i,
   input logic [7:0] status_o
);
   // R1
   full_write_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] && wr_en_i && !sleep_i && !(clr_wr_i && clr_data_i[4]) |=> status_o[4]);
   // R2
   full_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] |-> status_o[6]);
   // R3
   level_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[5] |-> status_o[6]);
   // R4
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[4] && !(clr_wr_i && clr_data_i[4]) |=> status_o[4]);
   // R4
   sleep_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i && !status_o[4] |=> !status_o[4]);
   // R5
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr_i && clr_data_i[4] |=> (status_o[7:1] == 7'd0));
   // R8
   empty_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[6] |-> (status_o[2:1] == 2'd0));
   // R9
   lbat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[0] && !(clr_wr_i && clr_data_i[0]) |=> status_o[0]);
   // R11
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[6] && rd_en_i && !wr_en_i |=> !status_o[6]);
endmodule

bind rxq_status_fifo rxq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_i    (sleep_i),
   .wr_en_i    (wr_en_i),
   .rd_en_i    (rd_en_i),
   .clr_wr_i   (clr_wr_i),
   .clr_data_i (clr_data_i),
   .status_o   (status_o)
);

// File: tb/sim_rxq_status_fifo.sv
`timescale 1ns/1ps
module sim_rxq_status_fifo;
   localparam int DEPTH = 66;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_i = 0, rx_mode_i = 0, wr_en_i = 0, rd_en_i = 0;
   logic [7:0] wr_data_i = 0, clr_data_i = 0;
   logic [6:0] level_thr_i = 0;
   logic       payload_end_i = 0, crc_good_i = 0, crc_en_i = 0, autoclr_off_i = 0;
   logic       lowbat_evt_i = 0, clr_wr_i = 0;
   logic [7:0] rd_data_o, status_o;

   always #5 clk = ~clk;

   rxq_status_fifo u0 (.*);

   // reference model
   logic [7:0] mq[$];
   bit m_ovr, m_pr, m_ck, m_lb;
   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      logic [7:0] s = '0;
      s[7] = (mq.size() == DEPTH);
      s[6] = (mq.size() != 0);
      s[5] = (mq.size() > int'(level_thr_i));
      s[4] = m_ovr;
      s[2] = m_pr;
      s[1] = m_ck;
      s[0] = m_lb;
      return s;
   endfunction

   task automatic model_update();
      bit full_now = (mq.size() == DEPTH);
      if (clr_wr_i && clr_data_i[4]) begin
         mq.delete();
         m_ovr = 0;
      end else begin
         if (rd_en_i && mq.size() != 0) void'(mq.pop_front());
         if (wr_en_i) begin
            if (full_now) begin
               if (!sleep_i) m_ovr = 1;
            end else mq.push_back(wr_data_i);
         end
      end
      if (rx_mode_i && payload_end_i) begin
         if (!crc_en_i || autoclr_off_i || crc_good_i) m_pr = 1;
         if (crc_good_i) m_ck = 1;
      end
      if (mq.size() == 0) begin m_pr = 0; m_ck = 0; end
      if (lowbat_evt_i) m_lb = 1;
      else if (clr_wr_i && clr_data_i[0]) m_lb = 0;
   endtask

   task automatic compare();
      logic [7:0] e = exp_status();
      chk("R1 full",          status_o[7], e[7]);
      chk("R2 not-empty",     status_o[6], e[6]);
      chk("R3 level",         status_o[5], e[5]);
      chk("R4 overflow",      status_o[4], e[4]);
      chk("R10 bit3",         status_o[3], 0);
      chk("R6 payload-ready", status_o[2], e[2]);
      chk("R7 check-passed",  status_o[1], e[1]);
      chk("R9 supply",        status_o[0], e[0]);
      chk("R11 head data",    rd_data_o, (mq.size() != 0) ? mq[0] : 0);
   endtask

   task automatic tick();
      @(posedge clk);
      #1 model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      wr_en_i = 0; rd_en_i = 0; payload_end_i = 0; lowbat_evt_i = 0;
      clr_wr_i = 0; clr_data_i = 0;
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      report();
   end

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R10 reset status", status_o, 0);
      chk("R11 reset data", rd_data_o, 0);

      // R11: read while empty is ignored
      level_thr_i = 7'd3;
      rd_en_i = 1; tick(); idle();
      chk("R11 empty read", status_o[6], 0);

      // R1: fill to exactly 66
      rx_mode_i = 1;
      for (int i = 0; i < DEPTH; i++) begin
         wr_en_i = 1; wr_data_i = 8'(i + 1); tick();
      end
      idle();
      chk("R1 full at 66", status_o[7], 1);
      // R4: write while full sets overflow, data unchanged
      wr_en_i = 1; wr_data_i = 8'hEE; tick(); idle();
      chk("R4 overflow set", status_o[4], 1);
      chk("R1 data kept", rd_data_o, 1);
      // R6/R7: payload end with good check
      crc_en_i = 1; crc_good_i = 1; payload_end_i = 1; tick(); idle();
      chk("R6 ready set", status_o[2], 1);
      // R5: flush with a write in the same cycle
      clr_wr_i = 1; clr_data_i = 8'h10; wr_en_i = 1; wr_data_i = 8'h55; tick(); idle();
      chk("R5 flush empties", status_o & 8'hFE, 0);
      wr_en_i = 1; wr_data_i = 8'h66; tick(); idle();
      chk("R5 next write taken", rd_data_o, 8'h66);
      // R6: check enabled, bad result, auto-clear off low -> no ready
      crc_good_i = 0; payload_end_i = 1; tick(); idle();
      chk("R6 blocked by bad check", status_o[2], 0);
      autoclr_off_i = 1; payload_end_i = 1; tick(); idle();
      chk("R6 auto-clear off", status_o[2], 1);
      // R8: drain clears ready
      rd_en_i = 1; tick(); idle();
      chk("R8 drained", status_o[2], 0);
      // R9: set wins over clear
      lowbat_evt_i = 1; clr_wr_i = 1; clr_data_i = 8'h01; tick(); idle();
      chk("R9 set wins", status_o[0], 1);
      clr_wr_i = 1; clr_data_i = 8'h01; tick(); idle();
      chk("R9 cleared", status_o[0], 0);

      // constrained random phases
      for (int i = 0; i < 4000; i++) begin
         int ph = (i / 250) % 4;
         int r = $urandom % 100;
         wr_en_i = (ph == 0) ? (r < 85) : (ph == 1) ? (r < 15) : (r < 50);
         rd_en_i = (ph == 0) ? ($urandom % 100 < 15) : (ph == 1) ? ($urandom % 100 < 85)
                             : ($urandom % 2 == 1);
         wr_data_i = 8'($urandom);
         sleep_i = (ph == 3) ? ($urandom % 2 == 1) : 1'b0;
         rx_mode_i = ($urandom % 8 != 0);
         payload_end_i = ($urandom % 16 == 0);
         crc_good_i = $urandom % 2; crc_en_i = $urandom % 2; autoclr_off_i = $urandom % 2;
         lowbat_evt_i = ($urandom % 40 == 0);
         clr_wr_i = ($urandom % 20 == 0);
         clr_data_i = 8'($urandom) & (($urandom % 8 == 0) ? 8'hFF : 8'hEF);
         if ($urandom % 30 == 0) level_thr_i = 7'($urandom % 70);
         tick();
      end
      idle();
      tick();
      report();
   end
endmodule